// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block models a byte-addressed serial EEPROM that answers as a target on a two-wire open-drain bus. It watches the clock and data lines (sampled by the block's own system clock), recognises bus START and STOP conditions, decodes a control byte that carries a fixed device code, a three-bit strap-selected chip address and a read/write flag, and then takes a 15-bit word address as two bytes, high byte first. Writes collect up to one page of data in a page buffer. The buffer is copied into the storage array only after the controller sends STOP. A parameterised busy period then follows, during which the target acknowledges nothing.

Reads come from an internal address pointer. The pointer can be loaded by a dummy write (random read) or reused as it stands (current-address read). The target keeps sending bytes for as long as the controller acknowledges them (sequential read). A write-protect input lets the target acknowledge a whole write but leaves the stored data untouched. The storage array holds 2^MEM_AW bytes and is indexed by the low MEM_AW bits of the 15-bit pointer, so a small array can stand in for the full address space in simulation.

Top module: `twi_eeprom_target`

## Requirements
- R1: A control byte is acknowledged only when its bits 7..4 equal 4'b1010, its bits 3..1 equal `strap_i`, and no write cycle is running. Bit 0 selects the direction (1 = read, 0 = write). Any other control byte gets no ACK, and the target drives nothing until the next START.
- R2: SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP. A STOP returns the target to idle with SDA released. A START at any point restarts control-byte decoding, and the data bytes of a write that is interrupted this way are discarded without starting a write cycle.
- R3: Every byte is transferred MSB first. The target changes its SDA drive only while SCL is low.
- R4: After a write control byte the target acknowledges two address bytes, high byte first. Bit 7 of the high byte is ignored, and the storage location is the low MEM_AW bits of the resulting 15-bit address.
- R5: Data bytes of a write are acknowledged and held. They are stored only when a STOP follows at least one data byte, and that STOP starts the internal write cycle.
- R6: During a write only the low 6 address bits advance after each data byte, so bytes past the end of a 64-byte page wrap to the start of the same page and overwrite it.
- R7: For WRITE_CYCLES clock cycles after the STOP that starts a write cycle, the target acknowledges no byte, including a control byte that matches.
- R8: While `wp_i` is high, every byte of a write is still acknowledged, but the stored contents stay unchanged.
- R9: A current-address read returns the byte at the last accessed address plus one, after either a write or a read.
- R10: A random read (write control byte, two address bytes, repeated START, read control byte) returns the byte at the given address.
- R11: In a read, the target sends the next byte each time the controller ACKs and releases SDA after a NACK. The pointer wraps from 0x7FFF to 0x0000.
- R12: After reset the target does not drive SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_low_o | output | 1 | 1 pulls SDA low; 0 releases it |
| strap_i | input | 3 | Chip address straps |
| wp_i | input | 1 | Write protect, active high |

## Verification
A wrong decode or pointer state shows on SDA within one bit period: a missing or unexpected ACK in the ninth clock of the byte concerned, or a wrong data bit in the next byte read. A fault in the page buffer or the commit path shows nothing on the bus while the write runs. It appears only when the location is read back after the write cycle, so every write is followed by acknowledge polling and a readback. The polling itself shows whether the busy window is the right length.

// File: rtl/twi_ee_pkg.sv
package twi_ee_pkg;

    localparam int         WORD_AW  = 15;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_ACK,
        PH_TX,
        PH_MACK
    } phase_e;

    typedef enum logic [1:0] {
        BK_CTRL,
        BK_AHI,
        BK_ALO,
        BK_DATA
    } byte_kind_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic [3:0] code;
        logic [2:0] chip;
        logic       rd;
    } ctrl_t;

    // advance only the in-page bits of an address
    function automatic logic [WORD_AW-1:0] page_step(
        input logic [WORD_AW-1:0] a,
        input int unsigned        paw
    );
        logic [WORD_AW-1:0] m;
        m = WORD_AW'((1 << paw) - 1);
        return (a & ~m) | ((a + 1'b1) & m);
    endfunction

endpackage

// File: rtl/twi_ee_linemon.sv
module twi_ee_linemon
    import twi_ee_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic [1:0] scl_sy, sda_sy;
    logic       scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sy <= 2'b11;
            sda_sy <= 2'b11;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sy <= {scl_sy[0], scl_i};
            sda_sy <= {sda_sy[0], sda_i};
            scl_q  <= scl_sy[1];
            sda_q  <= sda_sy[1];
        end
    end

    always_comb begin
        ev.scl   = scl_sy[1];
        ev.sda   = sda_sy[1];
        ev.rise  = scl_sy[1] & ~scl_q;
        ev.fall  = ~scl_sy[1] & scl_q;
        ev.start = scl_sy[1] & scl_q & sda_q & ~sda_sy[1];
        ev.stop  = scl_sy[1] & scl_q & ~sda_q & sda_sy[1];
    end

endmodule

// File: rtl/twi_ee_store.sv
module twi_ee_store
    import twi_ee_pkg::*;
#(
    parameter int MEM_AW       = 8,
    parameter int PAGE_AW      = 6,
    parameter int WRITE_CYCLES = 400
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      buf_clr,
    input  logic                      buf_we,
    input  logic                      buf_keep,
    input  logic [PAGE_AW-1:0]        buf_idx,
    input  logic [7:0]                buf_din,
    input  logic                      commit,
    input  logic [MEM_AW-PAGE_AW-1:0] page_num,
    input  logic [MEM_AW-1:0]         rd_addr,
    output logic [7:0]                rd_data,
    output logic                      busy
);

    localparam int PAGE_B   = 1 << PAGE_AW;
    localparam int MEM_B    = 1 << MEM_AW;
    localparam int HI_W     = MEM_AW - PAGE_AW;
    localparam int BUSY_LEN = (WRITE_CYCLES > PAGE_B) ? WRITE_CYCLES : PAGE_B + 1;
    localparam int CNT_W    = $clog2(BUSY_LEN + 1);

    logic [7:0]        mem  [MEM_B];
    logic [7:0]        pbuf [PAGE_B];
    logic [PAGE_B-1:0] pval;
    logic [HI_W-1:0]   cpage;
    logic [CNT_W-1:0]  busy_cnt;
    logic [PAGE_AW:0]  sweep;
    logic              sweep_on;
    logic              mem_we;
    logic [PAGE_AW-1:0] sw_i;

    assign sweep_on = ~sweep[PAGE_AW];
    assign sw_i     = sweep[PAGE_AW-1:0];
    assign mem_we   = sweep_on & pval[sw_i];
    assign busy     = (busy_cnt != '0);
    assign rd_data  = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_cnt <= '0;
            sweep    <= {1'b1, {PAGE_AW{1'b0}}};
            cpage    <= '0;
            pval     <= '0;
        end else begin
            if (commit) begin
                busy_cnt <= CNT_W'(BUSY_LEN);
                sweep    <= '0;
                cpage    <= page_num;
            end else begin
                if (busy) busy_cnt <= busy_cnt - 1'b1;
                if (sweep_on) sweep <= sweep + 1'b1;
            end
            if (buf_clr) begin
                pval <= '0;
            end else if (buf_we && buf_keep) begin
                pval[buf_idx] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (buf_we && buf_keep) pbuf[buf_idx] <= buf_din;
    end

    always_ff @(posedge clk) begin
        if (mem_we) mem[{cpage, sw_i}] <= pbuf[sw_i];
    end

    // R5: the array changes only inside a write cycle
    a_r5_store_in_cycle: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    // R5: a new write cycle never starts on top of a running one
    a_r5_commit_not_busy: assert property (@(posedge clk) disable iff (rst)
        commit |-> !busy);

endmodule

// File: rtl/twi_ee_fsm.sv
module twi_ee_fsm
    import twi_ee_pkg::*;
#(
    parameter int MEM_AW  = 8,
    parameter int PAGE_AW = 6
) (
    input  logic                      clk,
    input  logic                      rst,
    input  bus_ev_t                   ev,
    input  logic [2:0]                strap_i,
    input  logic                      wp_i,
    input  logic                      busy,
    input  logic [7:0]                rd_data,
    output logic                      sda_low,
    output logic [MEM_AW-1:0]         rd_addr,
    output logic                      buf_clr,
    output logic                      buf_we,
    output logic                      buf_keep,
    output logic [PAGE_AW-1:0]        buf_idx,
    output logic [7:0]                buf_din,
    output logic                      commit,
    output logic [MEM_AW-PAGE_AW-1:0] page_num
);

    phase_e             ph;
    byte_kind_e         kind;
    logic               go_tx;
    logic [3:0]         bitcnt;
    logic [7:0]         rsh, tsh;
    logic [WORD_AW-1:0] ptr;
    logic [6:0]         ahi;
    logic               mack;
    logic               pend;
    ctrl_t              cb;
    logic               ctrl_hit;
    logic               rx_done;

    assign cb       = ctrl_t'(rsh);
    assign ctrl_hit = (cb.code == DEV_CODE) && (cb.chip == strap_i) && !busy;
    assign rx_done  = (ph == PH_RX) && ev.fall && (bitcnt == 4'd8) && !ev.start && !ev.stop;

    assign sda_low  = (ph == PH_ACK) || ((ph == PH_TX) && !tsh[7]);
    assign rd_addr  = ptr[MEM_AW-1:0];
    assign buf_clr  = rx_done && (kind == BK_ALO);
    assign buf_we   = rx_done && (kind == BK_DATA);
    assign buf_keep = ~wp_i;
    assign buf_idx  = ptr[PAGE_AW-1:0];
    assign buf_din  = rsh;
    assign commit   = ev.stop && pend;
    assign page_num = ptr[MEM_AW-1:PAGE_AW];

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            kind   <= BK_CTRL;
            go_tx  <= 1'b0;
            bitcnt <= '0;
            rsh    <= '0;
            tsh    <= 8'hFF;
            ptr    <= '0;
            ahi    <= '0;
            mack   <= 1'b1;
            pend   <= 1'b0;
        end else if (ev.stop) begin
            ph   <= PH_IDLE;
            pend <= 1'b0;
        end else if (ev.start) begin
            ph     <= PH_RX;
            kind   <= BK_CTRL;
            bitcnt <= '0;
            pend   <= 1'b0;
        end else begin
            case (ph)
                PH_RX: begin
                    if (ev.rise) begin
                        rsh    <= {rsh[6:0], ev.sda};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (rx_done) begin
                        bitcnt <= '0;
                        go_tx  <= 1'b0;
                        ph     <= PH_ACK;
                        case (kind)
                            BK_CTRL: begin
                                if (ctrl_hit) begin
                                    go_tx <= cb.rd;
                                    kind  <= BK_AHI;
                                end else begin
                                    ph <= PH_IDLE;
                                end
                            end
                            BK_AHI: begin
                                ahi  <= rsh[6:0];
                                kind <= BK_ALO;
                            end
                            BK_ALO: begin
                                ptr  <= {ahi, rsh};
                                kind <= BK_DATA;
                            end
                            default: begin
                                ptr  <= page_step(ptr, PAGE_AW);
                                pend <= 1'b1;
                            end
                        endcase
                    end
                end
                PH_ACK: begin
                    if (ev.fall) begin
                        if (go_tx) begin
                            tsh    <= rd_data;
                            ptr    <= ptr + 1'b1;
                            bitcnt <= '0;
                            ph     <= PH_TX;
                        end else begin
                            ph <= PH_RX;
                        end
                    end
                end
                PH_TX: begin
                    if (ev.fall) begin
                        if (bitcnt == 4'd7) begin
                            ph <= PH_MACK;
                        end else begin
                            tsh    <= {tsh[6:0], 1'b1};
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                PH_MACK: begin
                    if (ev.rise) begin
                        mack <= ev.sda;
                    end else if (ev.fall) begin
                        if (!mack) begin
                            tsh    <= rd_data;
                            ptr    <= ptr + 1'b1;
                            bitcnt <= '0;
                            ph     <= PH_TX;
                        end else begin
                            ph <= PH_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R7: no acknowledge slot is driven while the write cycle runs
    a_r7_no_ack_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> (ph != PH_ACK));

    // R6: accepting a data byte never moves the pointer out of its page
    a_r6_page_hold: assert property (@(posedge clk) disable iff (rst)
        buf_we |=> $stable(ptr[WORD_AW-1:PAGE_AW]));

    // R3: the SDA drive holds steady across an SCL high phase
    a_r3_drive_steady: assert property (@(posedge clk) disable iff (rst)
        (ev.scl && $past(ev.scl) && !$past(ev.start) && !$past(ev.stop))
            |-> $stable(sda_low));

    // R2: a STOP always lands in idle
    a_r2_idle_after_stop: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (ph == PH_IDLE) && !sda_low);

endmodule

// File: rtl/twi_eeprom_target.sv
module twi_eeprom_target
    import twi_ee_pkg::*;
#(
    parameter int MEM_AW       = 8,
    parameter int PAGE_AW      = 6,
    parameter int WRITE_CYCLES = 400
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_low_o,
    input  logic [2:0] strap_i,
    input  logic       wp_i
);

    localparam int HI_W = MEM_AW - PAGE_AW;

    bus_ev_t            ev;
    logic               busy;
    logic [7:0]         rd_data;
    logic [MEM_AW-1:0]  rd_addr;
    logic               buf_clr, buf_we, buf_keep, commit;
    logic [PAGE_AW-1:0] buf_idx;
    logic [7:0]         buf_din;
    logic [HI_W-1:0]    page_num;

    twi_ee_linemon u_linemon (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    twi_ee_fsm #(
        .MEM_AW  (MEM_AW),
        .PAGE_AW (PAGE_AW)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .strap_i  (strap_i),
        .wp_i     (wp_i),
        .busy     (busy),
        .rd_data  (rd_data),
        .sda_low  (sda_low_o),
        .rd_addr  (rd_addr),
        .buf_clr  (buf_clr),
        .buf_we   (buf_we),
        .buf_keep (buf_keep),
        .buf_idx  (buf_idx),
        .buf_din  (buf_din),
        .commit   (commit),
        .page_num (page_num)
    );

    twi_ee_store #(
        .MEM_AW       (MEM_AW),
        .PAGE_AW      (PAGE_AW),
        .WRITE_CYCLES (WRITE_CYCLES)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .buf_clr  (buf_clr),
        .buf_we   (buf_we),
        .buf_keep (buf_keep),
        .buf_idx  (buf_idx),
        .buf_din  (buf_din),
        .commit   (commit),
        .page_num (page_num),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .busy     (busy)
    );

endmodule

// File: tb/twi_eeprom_target_tb.sv
`timescale 1ns/1ps
module twi_eeprom_target_tb;

    localparam int         Q    = 4;
    localparam logic [2:0] CHIP = 3'b101;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       m_low = 1'b0;
    logic       wp = 1'b0;
    logic [2:0] strap = CHIP;
    logic       s_low;
    logic       sda_line;

    always #4 clk = ~clk;
    always_comb sda_line = ~(m_low | s_low);

    twi_eeprom_target u_dut (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .sda_low_o (s_low),
        .strap_i   (strap),
        .wp_i      (wp)
    );

    int errors = 0;
    int checks = 0;

    logic [7:0]  model [256];
    logic [14:0] bptr = '0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard: expected read bytes and their tags
    logic [7:0] exp_q [$];
    string      tag_q [$];
    bit         mon_on = 1'b0;
    int         mon_bits = 0;
    logic [7:0] mon_sh = '0;
    logic [7:0] mon_e;
    string      mon_t;

    always @(posedge scl) begin
        if (mon_on) begin
            mon_sh = {mon_sh[6:0], sda_line};
            mon_bits++;
            if (mon_bits == 8) begin
                mon_bits = 0;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R11 unexpected read byte", int'(mon_sh), 0);
                end else begin
                    mon_e = exp_q.pop_front();
                    mon_t = tag_q.pop_front();
                    chk(mon_sh == mon_e, mon_t, int'(mon_sh), int'(mon_e));
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input bit b);
        m_low = ~b;
        tick(Q);
        scl = 1'b1;
        tick(2 * Q);
        scl = 1'b0;
        tick(Q);
    endtask

    task automatic bus_start();
        m_low = 1'b0;
        tick(Q);
        scl = 1'b1;
        tick(Q);
        m_low = 1'b1;
        tick(Q);
        scl = 1'b0;
        tick(Q);
    endtask

    task automatic bus_stop();
        m_low = 1'b1;
        tick(Q);
        scl = 1'b1;
        tick(Q);
        m_low = 1'b0;
        tick(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        m_low = 1'b0;
        tick(Q);
        scl = 1'b1;
        tick(Q);
        acked = ~sda_line;
        tick(Q);
        scl = 1'b0;
        tick(Q);
    endtask

    task automatic recv_byte(input bit give_ack);
        mon_on = 1'b1;
        for (int i = 0; i < 8; i++) bit_out(1'b1);
        mon_on = 1'b0;
        bit_out(~give_ack);
        m_low = 1'b0;
    endtask

    task automatic send_chk(input logic [7:0] b, input bit want, input string tag);
        bit a;
        send_byte(b, a);
        chk(a == want, tag, int'(a), int'(want));
    endtask

    function automatic logic [7:0] ctrl(input bit rd);
        return {4'b1010, CHIP, rd};
    endfunction

    task automatic addr_phase(input logic [15:0] a, input string tag);
        bus_start();
        send_chk(ctrl(1'b0), 1'b1, {tag, " R1 control ACK"});
        send_chk(a[15:8], 1'b1, {tag, " R4 high address ACK"});
        send_chk(a[7:0], 1'b1, {tag, " R4 low address ACK"});
    endtask

    // acknowledge polling after a write
    task automatic poll(input bit expect_busy, input string tag);
        bit a;
        bit done = 1'b0;
        for (int t = 0; t < 20 && !done; t++) begin
            bus_start();
            send_byte(ctrl(1'b0), a);
            if (t == 0 && expect_busy)
                chk(!a, {tag, " R7 first poll NACK while busy"}, int'(a), 0);
            bus_stop();
            done = a;
        end
        chk(done, {tag, " R7 ACK after write cycle"}, int'(done), 1);
    endtask

    task automatic write_bytes(input logic [15:0] a, input logic [7:0] d [8],
                               input int n, input string tag);
        logic [14:0] aa;
        aa = a[14:0];
        addr_phase(a, tag);
        for (int i = 0; i < n; i++) begin
            send_chk(d[i], 1'b1, {tag, " R5 data ACK"});
            if (!wp) model[aa[7:0]] = d[i];
            aa = {aa[14:6], aa[5:0] + 6'd1};
        end
        bus_stop();
        bptr = aa;
        poll(1'b1, tag);
    endtask

    task automatic read_seq(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(model[bptr[7:0]]);
            tag_q.push_back(tag);
            bptr = bptr + 15'd1;
            recv_byte(i < n - 1);
        end
        bus_stop();
    endtask

    task automatic rand_read(input logic [15:0] a, input int n, input string tag);
        addr_phase(a, tag);
        bus_start();
        send_chk(ctrl(1'b1), 1'b1, {tag, " R10 read control ACK"});
        bptr = a[14:0];
        read_seq(n, tag);
    endtask

    task automatic cur_read(input int n, input string tag);
        bus_start();
        send_chk(ctrl(1'b1), 1'b1, {tag, " R9 read control ACK"});
        read_seq(n, tag);
    endtask

    logic [7:0] d8 [8];

    initial begin : main
        bit a;
        tick(5);
        rst = 1'b0;
        tick(5);
        chk(s_low == 1'b0, "R12 SDA released after reset", int'(s_low), 0);

        d8 = '{8'hA5, 0, 0, 0, 0, 0, 0, 0};
        write_bytes(16'h0010, d8, 1, "R5 byte write");

        d8 = '{8'h11, 8'h22, 8'h33, 8'h44, 0, 0, 0, 0};
        write_bytes(16'h0020, d8, 4, "R6 page write");

        rand_read(16'h0010, 1, "R3 R10 random read");
        rand_read(16'h0020, 1, "R10 random read");
        cur_read(1, "R9 current address read");
        cur_read(2, "R11 sequential read");

        // page wrap: 0x7C..0x7F then 0x40, 0x41
        d8 = '{8'hB0, 8'hB1, 8'hB2, 8'hB3, 8'hB4, 8'hB5, 0, 0};
        write_bytes(16'h007C, d8, 6, "R6 wrap write");
        rand_read(16'h007C, 4, "R6 page tail");
        rand_read(16'h0040, 2, "R6 wrapped to page start");

        rand_read(16'h8020, 1, "R4 high address bit 7 ignored");

        // non-matching control bytes
        bus_start();
        send_chk({4'b1010, 3'b011, 1'b0}, 1'b0, "R1 wrong chip address NACK");
        chk(s_low == 1'b0, "R1 SDA released after mismatch", int'(s_low), 0);
        bus_stop();
        bus_start();
        send_chk({4'b1011, CHIP, 1'b1}, 1'b0, "R1 wrong device code NACK");
        bus_stop();
        chk(s_low == 1'b0, "R2 SDA released after STOP", int'(s_low), 0);

        // write protect
        wp = 1'b1;
        d8 = '{8'h5A, 8'h5B, 0, 0, 0, 0, 0, 0};
        write_bytes(16'h0010, d8, 2, "R8 protected write");
        wp = 1'b0;
        rand_read(16'h0010, 2, "R8 contents unchanged");

        // end-of-memory wrap
        d8 = '{8'hEE, 0, 0, 0, 0, 0, 0, 0};
        write_bytes(16'h7FFF, d8, 1, "R11 write top");
        d8 = '{8'h77, 0, 0, 0, 0, 0, 0, 0};
        write_bytes(16'h0000, d8, 1, "R11 write bottom");
        rand_read(16'h7FFF, 2, "R11 wrap 7FFF to 0000");

        // write cut off by a repeated START
        d8 = '{8'h12, 0, 0, 0, 0, 0, 0, 0};
        write_bytes(16'h0030, d8, 1, "R2 setup");
        addr_phase(16'h0030, "R2 abort");
        send_chk(8'h99, 1'b1, "R2 abort data ACK");
        bus_start();
        send_byte(ctrl(1'b0), a);
        chk(a, "R2 no write cycle after START", int'(a), 1);
        bus_stop();
        rand_read(16'h0030, 1, "R2 aborted data discarded");

        tick(20);
        chk(exp_q.size() == 0, "R11 all expected bytes seen", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : watchdog
        repeat (180000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule